// File: doc/BRIEF.md
# CMOS RAM access lock controller

This block guards a 256-byte battery-backed CMOS RAM that is organised as two banks of 128 bytes, a lower bank and an upper bank. Software programs an 8-bit guard register through a simple register port. That register holds three control bits:

- an enable that opens the upper bank;
- a sticky seal for the lower bank;
- a sticky seal for the upper bank.

Each seal closes the eight-byte window at indices 38h..3Fh of its own bank. The seal can be set but never cleared by software. Only a hardware reset clears it.

A RAM access port carries a bank select, a 7-bit byte index, read and write strobes and write data. The block contains the RAM storage itself. Permitted writes update the storage, and blocked writes are dropped. Every read returns a response exactly one cycle later. A permitted read returns the stored byte, and a blocked read returns FFh.

Top module: `cmos_lock_ctrl`

## Requirements
- R1: After reset the guard register reads 00h, and `ram_rvalid` is 0.
- R2: Guard register bit 4 is the upper-bank seal, bit 3 is the lower-bank seal and bit 2 is the upper-bank enable. Bits 7:5 and 1:0 ignore writes and always read 0.
- R3: While the lower seal is 1, lower-bank indices 38h..3Fh are blocked. Writes leave the RAM unchanged and reads return FFh. Other lower indices and the whole upper bank are unaffected.
- R4: While the upper seal is 1, upper-bank indices 38h..3Fh are blocked in the same way. Lower-bank bytes at the same indices are unaffected.
- R5: Writing 0 to a seal bit that is already 1 leaves it at 1. A hardware reset returns it to 0.
- R6: While the upper enable is 0, every upper-bank write is dropped and every upper-bank read returns FFh. Lower-bank accesses are unaffected.
- R7: The upper enable stays writable after a seal is set. Clearing the enable blocks the whole upper bank whatever the upper seal state is, and setting it again reopens the unsealed bytes.
- R8: A guard register write takes effect for RAM accesses from the next clock onward. An access in the same cycle as the register write is judged by the old register value.
- R9: A read strobe in one cycle gives `ram_rvalid` = 1 in the next cycle, for both permitted and blocked reads.
- R10: A permitted write followed by a permitted read of the same bank and index returns the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cfg_wr | input | 1 | Guard register write strobe |
| cfg_wdata | input | 8 | Guard register write data |
| cfg_rdata | output | 8 | Guard register read-back value |
| ram_bank | input | 1 | Bank select (0 = lower, 1 = upper) |
| ram_idx | input | 7 | Byte index within the bank |
| ram_rd | input | 1 | RAM read strobe |
| ram_wr | input | 1 | RAM write strobe |
| ram_wdata | input | 8 | RAM write data |
| ram_rdata | output | 8 | RAM read data, valid with ram_rvalid |
| ram_rvalid | output | 1 | Read response valid, one cycle after ram_rd |

## Verification
The hardest situation to reach from the ports is proving that a write to a sealed window really had no effect. While the seal is set, the window cannot be read back at all, because it returns FFh.

The bench therefore fills the window with known bytes first and then seals it. It attempts overwrites while sealed, applies a hardware reset to lift the seal (the storage has no reset), and reads the original bytes back.

The same-cycle ordering rule of R8 is reached by driving a guard register write and an upper-bank access on the same clock edge.

// File: rtl/cmos_lock_pkg.sv
package cmos_lock_pkg;
  localparam int DATA_W    = 8;
  localparam int IDX_W     = 7;
  localparam int ADDR_W    = IDX_W + 1;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int WIN_FIRST = 'h38;
  localparam int WIN_LAST  = 'h3F;
  localparam int POS_HI_SEAL = 4;
  localparam int POS_LO_SEAL = 3;
  localparam int POS_HI_OPEN = 2;
  localparam logic [DATA_W-1:0] BLOCKED_BYTE = '1;

  typedef struct packed {
    logic hi_seal;
    logic lo_seal;
    logic hi_open;
  } guard_t;

  function automatic logic in_window(input logic [IDX_W-1:0] idx);
    return (int'(idx) >= WIN_FIRST) && (int'(idx) <= WIN_LAST);
  endfunction

  function automatic logic access_ok(input guard_t g, input logic bank,
                                     input logic [IDX_W-1:0] idx);
    logic bank_closed;
    logic sealed;
    bank_closed = bank && !g.hi_open;
    sealed      = in_window(idx) && (bank ? g.hi_seal : g.lo_seal);
    return !bank_closed && !sealed;
  endfunction

  function automatic logic [DATA_W-1:0] pack_guard(input guard_t g);
    logic [DATA_W-1:0] v;
    v = '0;
    v[POS_HI_SEAL] = g.hi_seal;
    v[POS_LO_SEAL] = g.lo_seal;
    v[POS_HI_OPEN] = g.hi_open;
    return v;
  endfunction
endpackage

// File: rtl/cmos_guard_reg.sv
module cmos_guard_reg
  import cmos_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output guard_t            guard,
  output logic [DATA_W-1:0] rdata
);
  guard_t guard_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_q <= '0;
    end else if (wr) begin
      guard_q.hi_open <= wdata[POS_HI_OPEN];
      guard_q.lo_seal <= guard_q.lo_seal | wdata[POS_LO_SEAL];
      guard_q.hi_seal <= guard_q.hi_seal | wdata[POS_HI_SEAL];
    end
  end

  assign guard = guard_q;
  assign rdata = pack_guard(guard_q);

  assert_lo_seal_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    guard_q.lo_seal |=> guard_q.lo_seal);
  assert_hi_seal_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    guard_q.hi_seal |=> guard_q.hi_seal);
  assert_open_follows_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (guard_q.hi_open == $past(wdata[POS_HI_OPEN])));
endmodule

// File: rtl/cmos_access_gate.sv
module cmos_access_gate
  import cmos_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  guard_t           guard,
  input  logic             bank,
  input  logic [IDX_W-1:0] idx,
  input  logic             rd,
  input  logic             wr,
  output logic             rd_pass,
  output logic             wr_pass
);
  logic allow;

  assign allow   = access_ok(guard, bank, idx);
  assign rd_pass = rd && allow;
  assign wr_pass = wr && allow;

  assert_closed_bank_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bank && !guard.hi_open) |-> !wr_pass);
  assert_lo_window_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !bank && guard.lo_seal && idx[IDX_W-1:3] == 4'b0111) |-> !wr_pass);
  assert_hi_window_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bank && guard.hi_seal && idx[IDX_W-1:3] == 4'b0111) |-> !wr_pass);
endmodule

// File: rtl/cmos_byte_store.sv
module cmos_byte_store
  import cmos_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank,
  input  logic [IDX_W-1:0]  idx,
  input  logic              rd,
  input  logic              rd_pass,
  input  logic              wr_pass,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr;

  assign addr = {bank, idx};

  always_ff @(posedge clk) begin
    if (wr_pass) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_pass ? mem[addr] : BLOCKED_BYTE;
    end
  end

  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);
  assert_blocked_read_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !rd_pass) |=> (rdata == BLOCKED_BYTE));
endmodule

// File: rtl/cmos_lock_ctrl.sv
module cmos_lock_ctrl
  import cmos_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              ram_bank,
  input  logic [IDX_W-1:0]  ram_idx,
  input  logic              ram_rd,
  input  logic              ram_wr,
  input  logic [DATA_W-1:0] ram_wdata,
  output logic [DATA_W-1:0] ram_rdata,
  output logic              ram_rvalid
);
  guard_t guard_w;
  logic   rd_pass_w;
  logic   wr_pass_w;

  cmos_guard_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .guard (guard_w),
    .rdata (cfg_rdata)
  );

  cmos_access_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .guard   (guard_w),
    .bank    (ram_bank),
    .idx     (ram_idx),
    .rd      (ram_rd),
    .wr      (ram_wr),
    .rd_pass (rd_pass_w),
    .wr_pass (wr_pass_w)
  );

  cmos_byte_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .bank    (ram_bank),
    .idx     (ram_idx),
    .rd      (ram_rd),
    .rd_pass (rd_pass_w),
    .wr_pass (wr_pass_w),
    .wdata   (ram_wdata),
    .rdata   (ram_rdata),
    .rvalid  (ram_rvalid)
  );

  assert_closed_read_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd && ram_bank && !cfg_rdata[POS_HI_OPEN]) |=> (ram_rdata == BLOCKED_BYTE));
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7:5] == 3'b000) && (cfg_rdata[1:0] == 2'b00));
endmodule

// File: tb/sim_cmos_lock_ctrl.sv
`timescale 1ns/1ps
module sim_cmos_lock_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       ram_bank = 1'b0;
  logic [6:0] ram_idx = '0;
  logic       ram_rd = 1'b0;
  logic       ram_wr = 1'b0;
  logic [7:0] ram_wdata = '0;
  logic [7:0] ram_rdata;
  logic       ram_rvalid;
  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  cmos_lock_ctrl u0 (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic ram_write(input logic b, input logic [6:0] i, input logic [7:0] d);
    @(negedge clk);
    ram_bank = b; ram_idx = i; ram_wr = 1'b1; ram_wdata = d;
    @(negedge clk);
    ram_wr = 1'b0;
  endtask

  task automatic ram_read(input logic b, input logic [6:0] i, output logic [7:0] d);
    @(negedge clk);
    ram_bank = b; ram_idx = i; ram_rd = 1'b1;
    @(negedge clk);
    ram_rd = 1'b0;
    check("R9 rvalid", {7'd0, ram_rvalid}, 8'h01);
    d = ram_rdata;
  endtask

  task automatic t_reset();
    check("R1 cfg reset", cfg_rdata, 8'h00);
    check("R1 rvalid reset", {7'd0, ram_rvalid}, 8'h00);
  endtask

  task automatic t_layout();
    cfg_write(8'hE3);
    check("R2 reserved ignored", cfg_rdata, 8'h00);
    cfg_write(8'hFF);
    check("R2 bit layout", cfg_rdata, 8'h1C);
    do_reset();
    check("R5 reset clears seals", cfg_rdata, 8'h00);
  endtask

  task automatic t_enable();
    cfg_write(8'h04);
    ram_write(1'b0, 7'h10, 8'h11);
    ram_write(1'b1, 7'h10, 8'h22);
    ram_read(1'b0, 7'h10, rv); check("R10 lower rw", rv, 8'h11);
    ram_read(1'b1, 7'h10, rv); check("R10 upper rw", rv, 8'h22);
    cfg_write(8'h00);
    ram_read(1'b1, 7'h10, rv); check("R6 closed read", rv, 8'hFF);
    ram_write(1'b1, 7'h10, 8'h33);
    ram_read(1'b0, 7'h10, rv); check("R6 lower unaffected", rv, 8'h11);
    cfg_write(8'h04);
    ram_read(1'b1, 7'h10, rv); check("R6 closed write dropped", rv, 8'h22);
  endtask

  task automatic t_same_cycle();
    ram_write(1'b1, 7'h05, 8'hAA);
    cfg_write(8'h00);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'h04;
    ram_bank = 1'b1; ram_idx = 7'h05; ram_wr = 1'b1; ram_wdata = 8'h55;
    @(negedge clk);
    cfg_wr = 1'b0; ram_wr = 1'b0;
    ram_read(1'b1, 7'h05, rv); check("R8 old enable judged write", rv, 8'hAA);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'h00;
    ram_bank = 1'b1; ram_idx = 7'h05; ram_rd = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; ram_rd = 1'b0;
    check("R8 old enable judged read", ram_rdata, 8'hAA);
    cfg_write(8'h04);
  endtask

  task automatic t_lo_seal();
    cfg_write(8'h04);
    ram_write(1'b0, 7'h38, 8'hA1);
    ram_write(1'b0, 7'h3F, 8'hA2);
    ram_write(1'b0, 7'h37, 8'hA3);
    ram_write(1'b1, 7'h38, 8'hB1);
    cfg_write(8'h0C);
    ram_read(1'b0, 7'h38, rv); check("R3 sealed 38h read", rv, 8'hFF);
    ram_read(1'b0, 7'h3F, rv); check("R3 sealed 3Fh read", rv, 8'hFF);
    ram_read(1'b0, 7'h37, rv); check("R3 37h open", rv, 8'hA3);
    ram_read(1'b1, 7'h38, rv); check("R3 upper unaffected", rv, 8'hB1);
    ram_write(1'b0, 7'h38, 8'h00);
    ram_write(1'b0, 7'h37, 8'hC3);
    ram_read(1'b0, 7'h37, rv); check("R3 37h writable", rv, 8'hC3);
    cfg_write(8'h04);
    check("R5 lower seal sticky", cfg_rdata, 8'h0C);
    do_reset();
    check("R5 reset clears lower seal", cfg_rdata, 8'h00);
    cfg_write(8'h04);
    ram_read(1'b0, 7'h38, rv); check("R3 sealed write dropped", rv, 8'hA1);
  endtask

  task automatic t_hi_seal();
    cfg_write(8'h04);
    ram_write(1'b1, 7'h3A, 8'hD1);
    ram_write(1'b1, 7'h30, 8'hD2);
    ram_write(1'b0, 7'h3A, 8'hE1);
    cfg_write(8'h14);
    ram_read(1'b1, 7'h3A, rv); check("R4 sealed read", rv, 8'hFF);
    ram_read(1'b1, 7'h30, rv); check("R4 30h open", rv, 8'hD2);
    ram_read(1'b0, 7'h3A, rv); check("R4 lower unaffected", rv, 8'hE1);
    ram_write(1'b1, 7'h3A, 8'h00);
    cfg_write(8'h10);
    check("R7 enable cleared, seal kept", cfg_rdata, 8'h10);
    ram_read(1'b1, 7'h30, rv); check("R7 closed bank blocks", rv, 8'hFF);
    cfg_write(8'h14);
    ram_read(1'b1, 7'h30, rv); check("R7 reopened", rv, 8'hD2);
    do_reset();
    cfg_write(8'h04);
    ram_read(1'b1, 7'h3A, rv); check("R4 sealed write dropped", rv, 8'hD1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_enable();
    t_same_cycle();
    t_lo_seal();
    t_hi_seal();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule